// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

The block keeps wall-clock time as a running calendar. A prescaler counts strobes of a slow reference clock, for example 32.768 kHz, on the `ref_en` input. Each time the count passes a programmable divider value, it issues one tick. A small sequencer takes each tick through two steps. The first step, ADVANCE, steps the calendar by one second. The second step, COMPARE, raises the tick event flag and checks the new calendar against an alarm setting. The calendar is stored as packed binary fields. It holds a full four-digit year and a one-based month, and its day rollover follows month lengths and the Gregorian leap-year rule.

Software uses a 32-bit register port. Writes are synchronous and reads are combinational. The status register mixes two kinds of bits. The sticky event bits clear when a one is written to them, and the enable bits are plain read/write. Writing back a value just read therefore clears every pending event and leaves the enables as they were. The interrupt output stays high while any event flag is set together with its enable.

The sequencer has three states. IDLE waits for a tick and moves to ADVANCE when one arrives. ADVANCE always moves to COMPARE. COMPARE moves to ADVANCE if another tick is already present, and to IDLE otherwise.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the status register reads 0, the divider register reads 0, the time register reads 0 and the date register reads year 2000, month 1, day 1.
- R2: While the divider field is zero, no tick occurs and the time and date registers hold their values.
- R3: Writing divider D (D nonzero) to the divider register at offset 0x0C restarts the prescaler. With `ref_en` high on every cycle, the 1 Hz flag is still clear D cycles after that write and is set 3 cycles later.
- R4: The time register at offset 0x10 packs the hour in [16:12], the minute in [11:6] and the second in [5:0]. On a tick, the second wraps from 59 to 0 and carries into the minute. The minute wraps from 59 to 0 and carries into the hour. The hour wraps from 23 to 0 and carries into the day.
- R5: The date register at offset 0x14 packs the year in [20:9], the month (1 to 12) in [8:5] and the day in [4:0]. The day wraps to 1 after the last day of its month. February has 29 days when the year is divisible by 4, except years divisible by 100 that are not divisible by 400. Month 12 wraps to month 1 and increments the year.
- R6: Status at offset 0x08 has these bits: bit0 alarm event, bit1 tick event, bit4 alarm1 event. These event bits are sticky and clear when a 1 is written to them. Writing back the value read clears the pending events and keeps the enables.
- R7: Status bits 2 (alarm interrupt enable), 3 (tick interrupt enable) and 5 (alarm1 enable) are read/write. Writing zeros to the event bits leaves those bits unchanged.
- R8: When the calendar after a tick equals the alarm time register at 0x18 and the alarm date register at 0x1C, status bits 0 and 4 set. The alarm registers use the same layouts as the time and date registers.
- R9: `irq` is high exactly while (bit0 and bit2) or (bit1 and bit3) or (bit4 and bit5) holds, and it stays high until software clears the flag or its enable.
- R10: A software write to the time or date register takes priority over a tick in the same cycle. The written value is what the register holds next.
- R11: The divider register reads back the divider in [15:0] and a stored trim in [25:16]. All other bits read 0.
- R12: Alarm comparison happens once per tick, so an alarm event flag can rise only in the cycle after a COMPARE step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One strobe per reference-clock period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench steps the calendar one tick at a time across the boundaries most likely to be mishandled:
- minute, hour and day carries;
- thirty-day months;
- February in an ordinary year, a leap year, a century year and a year divisible by 400;
- New Year's Eve.

A design with a wrong leap rule would move from February 28 to March 1 in 2000 or 2024, or would stop on February 29 in 1900. Random calendar values are biased toward 59 and 23 and toward last days of the month, and they are checked against a model in the bench.

The bench also covers the following status and alarm behaviour:
- Writing enables with the event bits at zero must keep pending events. A design that cleared events on any write would lose them.
- Writing back a value read must keep the enables. A design that treated the whole register as write-one-to-clear would lose them.
- The alarm must fire only on an exact match of date and time.
- A zero divider must freeze time.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DIV   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_TIME  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DATE  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_ATIME = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_ADATE = 8'h1C;

    localparam int STAT_W = 6;
    // event bits (write-one-to-clear) and enable bits (read/write)
    localparam logic [STAT_W-1:0] EVT_MASK = 6'b010011;
    localparam logic [STAT_W-1:0] ENA_MASK = 6'b101100;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] mins;
        logic [5:0] secs;
    } tod_t;

    typedef struct packed {
        logic [11:0] year;
        logic [3:0]  month;
        logic [4:0]  day;
    } ymd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADVANCE,
        ST_COMPARE
    } seq_state_t;

    function automatic logic [4:0] month_days(input logic [3:0] m, input logic [11:0] y);
        logic leap;
        leap = ((y % 12'd4) == 12'd0 && (y % 12'd100) != 12'd0) || ((y % 12'd400) == 12'd0);
        case (m)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             running;

    assign running = (div_i != '0);
    assign tick_o  = ref_en && running && (cnt_q == div_i);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (ref_en && running) begin
            cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: a tick is always followed by at least one quiet cycle
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int RESET_YEAR = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_en,
    input  logic wr_time,
    input  logic wr_date,
    input  tod_t wtime,
    input  ymd_t wdate,
    output tod_t time_o,
    output ymd_t date_o
);
    tod_t t_q, t_n;
    ymd_t d_q, d_n;
    logic c_min, c_hour, c_day, c_month, c_year;

    always_comb begin
        t_n     = t_q;
        d_n     = d_q;
        c_min   = (t_q.secs >= 6'd59);
        c_hour  = c_min  && (t_q.mins >= 6'd59);
        c_day   = c_hour && (t_q.hour >= 5'd23);
        c_month = c_day  && (d_q.day >= month_days(d_q.month, d_q.year));
        c_year  = c_month && (d_q.month >= 4'd12);
        t_n.secs = c_min  ? 6'd0 : t_q.secs + 6'd1;
        if (c_min)   t_n.mins  = c_hour ? 6'd0 : t_q.mins + 6'd1;
        if (c_hour)  t_n.hour  = c_day ? 5'd0 : t_q.hour + 5'd1;
        if (c_day)   d_n.day   = c_month ? 5'd1 : d_q.day + 5'd1;
        if (c_month) d_n.month = c_year ? 4'd1 : d_q.month + 4'd1;
        if (c_year)  d_n.year  = d_q.year + 12'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
            d_q <= '{year: 12'(RESET_YEAR), month: 4'd1, day: 5'd1};
        end else if (wr_time || wr_date) begin
            if (wr_time) t_q <= wtime;
            if (wr_date) d_q <= wdate;
        end else if (adv_en) begin
            t_q <= t_n;
            d_q <= d_n;
        end
    end

    assign time_o = t_q;
    assign date_o = d_q;

    // R10: a software write wins over an advance in the same cycle
    a_r10_time_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time |=> time_o == $past(wtime));
    a_r10_date_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_date |=> date_o == $past(wdate));
    // R2: without an advance or a write the calendar holds
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_en && !wr_time && !wr_date) |=> ($stable(time_o) && $stable(date_o)));

endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              hz_set,
    input  logic              al_set,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] s_q, s_n;

    always_comb begin
        s_n = s_q;
        if (wr) begin
            s_n = (s_q & EVT_MASK & ~wdata) | (wdata & ENA_MASK);
        end
        s_n[0] = s_n[0] | al_set;
        s_n[4] = s_n[4] | al_set;
        s_n[1] = s_n[1] | hz_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_n;
    end

    assign stat_o = s_q;
    assign irq_o  = (s_q[0] & s_q[2]) | (s_q[1] & s_q[3]) | (s_q[4] & s_q[5]);

    // R6: writing one to the tick event clears it when no new tick lands
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[1] && !hz_set) |=> !stat_o[1]);
    // R7: enables take the written value
    a_r7_enables_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((stat_o & ENA_MASK) == ($past(wdata) & ENA_MASK)));
    // R9: the interrupt holds until software writes the status register
    a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr) |=> irq_o);

endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
    import rtc_cal_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int TRIM_W     = 10,
    parameter int RESET_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int TRIM_LSB = 16;
    localparam int TOD_W    = $bits(tod_t);
    localparam int YMD_W    = $bits(ymd_t);

    seq_state_t        state_q, state_n;
    logic              tick, adv_en, cmp_en, al_match;
    logic              wr_stat, wr_div, wr_time, wr_date, wr_atime, wr_adate;
    logic [DIV_W-1:0]  div_q;
    logic [TRIM_W-1:0] trim_q;
    tod_t              atime_q, time_w;
    ymd_t              adate_q, date_w;
    logic [STAT_W-1:0] stat_w;

    assign wr_stat  = bus_we && (bus_addr == OFF_STAT);
    assign wr_div   = bus_we && (bus_addr == OFF_DIV);
    assign wr_time  = bus_we && (bus_addr == OFF_TIME);
    assign wr_date  = bus_we && (bus_addr == OFF_DATE);
    assign wr_atime = bus_we && (bus_addr == OFF_ATIME);
    assign wr_adate = bus_we && (bus_addr == OFF_ADATE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            trim_q  <= '0;
            atime_q <= '0;
            adate_q <= '0;
        end else begin
            if (wr_div) begin
                div_q  <= bus_wdata[DIV_W-1:0];
                trim_q <= bus_wdata[TRIM_LSB +: TRIM_W];
            end
            if (wr_atime) atime_q <= tod_t'(bus_wdata[TOD_W-1:0]);
            if (wr_adate) adate_q <= ymd_t'(bus_wdata[YMD_W-1:0]);
        end
    end

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_en  (ref_en),
        .restart (wr_div),
        .div_i   (div_q),
        .tick_o  (tick)
    );

    // tick sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // tick sequencer: transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (tick) state_n = ST_ADVANCE;
            ST_ADVANCE: state_n = ST_COMPARE;
            ST_COMPARE: state_n = tick ? ST_ADVANCE : ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // tick sequencer: outputs
    always_comb begin
        adv_en = 1'b0;
        cmp_en = 1'b0;
        unique case (state_q)
            ST_ADVANCE: adv_en = 1'b1;
            ST_COMPARE: cmp_en = 1'b1;
            default:    ;
        endcase
    end

    rtc_calendar #(.RESET_YEAR(RESET_YEAR)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_en  (adv_en),
        .wr_time (wr_time),
        .wr_date (wr_date),
        .wtime   (tod_t'(bus_wdata[TOD_W-1:0])),
        .wdate   (ymd_t'(bus_wdata[YMD_W-1:0])),
        .time_o  (time_w),
        .date_o  (date_w)
    );

    assign al_match = cmp_en && (time_w == atime_q) && (date_w == adate_q);

    rtc_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_stat),
        .wdata  (bus_wdata[STAT_W-1:0]),
        .hz_set (cmp_en),
        .al_set (al_match),
        .stat_o (stat_w),
        .irq_o  (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_STAT:  bus_rdata[STAT_W-1:0] = stat_w;
            OFF_DIV:   begin
                bus_rdata[DIV_W-1:0]             = div_q;
                bus_rdata[TRIM_LSB +: TRIM_W]    = trim_q;
            end
            OFF_TIME:  bus_rdata[TOD_W-1:0] = time_w;
            OFF_DATE:  bus_rdata[YMD_W-1:0] = date_w;
            OFF_ATIME: bus_rdata[TOD_W-1:0] = atime_q;
            OFF_ADATE: bus_rdata[YMD_W-1:0] = adate_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R12: an alarm event can only rise right after a COMPARE step
    a_r12_alarm_once: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_w[4]) |-> $past(state_q) == ST_COMPARE);
    // R8: a match in COMPARE sets both alarm event bits
    a_r8_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        al_match |=> (stat_w[0] && stat_w[4]));

endmodule

// File: tb/rtc_cal_top_tb.sv
module rtc_cal_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    localparam int STEP_DIV = 8;

    always #4 clk = ~clk;

    rtc_cal_top u_dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all bus tasks are entered just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int mdays(input int m, input int y);
        bit leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (m == 2) return leap ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] pk_t(input int h, input int mi, input int s);
        return (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
    endfunction

    function automatic logic [31:0] pk_d(input int y, input int mo, input int d);
        return (32'(y) << 9) | (32'(mo) << 5) | 32'(d);
    endfunction

    // model of one second step
    function automatic logic [63:0] nxt(input logic [31:0] t, input logic [31:0] d);
        int h = int'(t[16:12]), mi = int'(t[11:6]), s = int'(t[5:0]);
        int y = int'(d[20:9]), mo = int'(d[8:5]), dy = int'(d[4:0]);
        s++;
        if (s > 59) begin s = 0; mi++; end
        if (mi > 59) begin mi = 0; h++; end
        if (h > 23) begin h = 0; dy++; end
        if (dy > mdays(mo, y)) begin dy = 1; mo++; end
        if (mo > 12) begin mo = 1; y++; end
        return {pk_d(y, mo, dy), pk_t(h, mi, s)};
    endfunction

    // load calendar/alarm, run exactly one tick, freeze again
    task automatic step(input logic [31:0] t, input logic [31:0] d,
                        input logic [31:0] at, input logic [31:0] ad,
                        input logic [31:0] ena, input string req);
        logic [31:0] v;
        logic [63:0] e;
        bit seen = 0;
        wr(8'h0C, 32'h0);
        wr(8'h08, ena | 32'h13);
        wr(8'h10, t);
        wr(8'h14, d);
        wr(8'h18, at);
        wr(8'h1C, ad);
        wr(8'h0C, STEP_DIV);
        for (int i = 0; i < 100; i++) begin
            rd(8'h08, v);
            if (v[1]) begin seen = 1; break; end
            @(negedge clk);
        end
        wr(8'h0C, 32'h0);
        check({req, " tick seen"}, 32'(seen), 32'd1);
        e = nxt(t, d);
        rd(8'h10, v); check({req, " time"}, v, e[31:0]);
        rd(8'h14, v); check({req, " date"}, v, e[63:32]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v, t, d;
        int y, mo, dy, h, mi, s;
        void'($urandom(32'd20240229));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h08, v); check("R1 status", v, 32'h0);
        rd(8'h0C, v); check("R1 divider", v, 32'h0);
        rd(8'h10, v); check("R1 time", v, 32'h0);
        rd(8'h14, v); check("R1 date", v, pk_d(2000, 1, 1));
        check("R1 irq", 32'(irq), 32'h0);

        // R11 divider/trim readback, high bits dropped
        wr(8'h0C, 32'hFFFF_0000);
        rd(8'h0C, v); check("R11 trim field", v, 32'h03FF_0000);
        wr(8'h0C, 32'h0155_7FFF);
        rd(8'h0C, v); check("R11 divider field", v, 32'h0155_7FFF);
        wr(8'h0C, 32'h0);

        // R2 frozen while divider zero; R10 write readback
        wr(8'h10, pk_t(12, 34, 56));
        wr(8'h14, pk_d(2031, 7, 9));
        repeat (200) @(negedge clk);
        rd(8'h10, v); check("R2 time frozen", v, pk_t(12, 34, 56));
        rd(8'h14, v); check("R10 date write stored", v, pk_d(2031, 7, 9));
        rd(8'h08, v); check("R2 no tick event", v, 32'h0);

        // R3 tick latency after divider write
        wr(8'h0C, 32'd20);
        repeat (20) @(negedge clk);
        rd(8'h08, v); check("R3 no tick yet", 32'(v[1]), 32'd0);
        repeat (3) @(negedge clk);
        rd(8'h08, v); check("R3 tick event", 32'(v[1]), 32'd1);
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h13);

        // R4 / R5 directed boundaries
        step(pk_t(5, 6, 59), pk_d(2010, 3, 3), 0, 0, 0, "R4 sec carry");
        step(pk_t(5, 59, 59), pk_d(2010, 3, 3), 0, 0, 0, "R4 min carry");
        step(pk_t(23, 59, 59), pk_d(2010, 3, 3), 0, 0, 0, "R4 hour carry");
        step(pk_t(23, 59, 59), pk_d(2010, 4, 30), 0, 0, 0, "R5 30-day month");
        step(pk_t(23, 59, 59), pk_d(2023, 2, 28), 0, 0, 0, "R5 Feb common");
        step(pk_t(23, 59, 59), pk_d(2024, 2, 28), 0, 0, 0, "R5 Feb leap");
        step(pk_t(23, 59, 59), pk_d(2024, 2, 29), 0, 0, 0, "R5 Feb 29");
        step(pk_t(23, 59, 59), pk_d(1900, 2, 28), 0, 0, 0, "R5 century");
        step(pk_t(23, 59, 59), pk_d(2000, 2, 28), 0, 0, 0, "R5 400-year");
        step(pk_t(23, 59, 59), pk_d(2099, 12, 31), 0, 0, 0, "R5 year end");

        // R8 / R9 alarm match with alarm1 enable
        step(pk_t(10, 20, 30), pk_d(2042, 6, 15), pk_t(10, 20, 31), pk_d(2042, 6, 15),
             32'h20, "R8 alarm step");
        rd(8'h08, v); check("R8 alarm events", v, 32'h33);
        check("R9 irq from alarm1", 32'(irq), 32'd1);
        // R7 enables written with zero event bits keep events
        wr(8'h08, 32'h24);
        rd(8'h08, v); check("R7 events kept", v, 32'h37);
        // R6 write-back clears events, keeps enables
        wr(8'h08, v);
        rd(8'h08, v); check("R6 write-back", v, 32'h24);
        check("R9 irq dropped", 32'(irq), 32'd0);

        // R8 near miss: different date, no alarm
        step(pk_t(10, 20, 30), pk_d(2042, 6, 15), pk_t(10, 20, 31), pk_d(2042, 6, 16),
             32'h24, "R8 miss step");
        rd(8'h08, v); check("R8 no alarm on miss", v, 32'h26);
        check("R9 irq off, tick disabled", 32'(irq), 32'd0);

        // R9 tick interrupt
        step(pk_t(1, 2, 3), pk_d(2050, 1, 1), 0, 0, 32'h08, "R9 tick step");
        check("R9 irq from tick", 32'(irq), 32'd1);
        wr(8'h08, 32'h13);
        check("R9 irq cleared", 32'(irq), 32'd0);
        wr(8'h08, 32'h0);

        // R4 / R5 random calendars biased to boundaries
        for (int k = 0; k < 60; k++) begin
            y  = 1900 + int'($urandom % 600);
            mo = 1 + int'($urandom % 12);
            dy = ($urandom % 2) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y));
            h  = ($urandom % 2) ? 23 : int'($urandom % 24);
            mi = ($urandom % 2) ? 59 : int'($urandom % 60);
            s  = ($urandom % 4 != 0) ? 59 : int'($urandom % 60);
            t = pk_t(h, mi, s);
            d = pk_d(y, mo, dy);
            step(t, d, 0, 0, 0, "R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule